// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block is the trap entry and trap return unit of a small processor core with three privilege levels. It keeps the current privilege level and interrupt enable, and two saved levels below them, in a three-deep stack. At each instruction boundary it decides whether a synchronous exception or a pending interrupt must be taken. It then pushes the stack and redirects fetch to a vector derived from the privilege level that was left. It also serves a trap-return request by popping the stack and redirecting fetch to the saved exception PC.

Control is a four-state machine. `ST_BOOT` is the reset state and issues the boot redirect. `ST_RUN` waits for instruction boundaries. `ST_ENTER` is the one-cycle trap-entry redirect. `ST_LEAVE` is the one-cycle trap-return redirect. The transitions are:

- `BOOT->RUN` always.
- `RUN->ENTER` on a boundary with a trap to take.
- `RUN->LEAVE` on a boundary with a return request and no trap.
- `RUN->RUN` otherwise.
- `ENTER->RUN` and `LEAVE->RUN` always.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `redirect` is 1 with `redirect_pc` = 0x100. Privilege encodings are user=0, supervisor=1, machine=3. After reset the current privilege is machine (3), both saved slots hold supervisor, all enables are 0, and `cause` and `epc` are 0.
- R2: On trap entry the stack shifts down. Slot 2 takes the old slot-1 level and enable, and slot 1 takes the old current level and enable. The current level becomes machine with the enable cleared.
- R3: On trap return the stack shifts up. The current level takes slot 1, and slot 1 takes slot 2. Slot 2 is refilled with user privilege and enable 1. The redirect target of a return is the saved `epc`.
- R4: The trap-entry redirect target is 0x40 times the privilege level in effect before the push: 0x00, 0x40 or 0xC0.
- R5: Machine-level interrupts (`m_sw_irq`, `host_irq`) are eligible when the privilege is below machine, or is machine with the enable set. The software interrupt wins over the host interrupt.
- R6: Supervisor-level interrupts (`s_sw_irq`, `s_tmr_irq`) are eligible when the privilege is user, or is supervisor with the enable set. Software wins over timer. The timer also needs `tmr_en`=1. Machine-level interrupts rank above supervisor-level ones.
- R7: An interrupt cause has bit 31 set and its low bits hold the interrupt number: software=0, timer=1, host=2. An exception cause is `exc_cause` zero-extended, with bit 31 clear.
- R8: On trap entry, `epc` takes `pc_in` sampled at the boundary. `resv_kill` pulses for one cycle together with the entry redirect, and never on a return.
- R9: At one boundary, an eligible interrupt wins over an exception, and any trap wins over a return request.
- R10: Requests are acted on only when `insn_bnd` is 1 in `ST_RUN`. Any redirect lasts exactly one cycle, and the result appears in the cycle after the boundary.
- R11: A pulse on `ien_we` writes `ien_d` into the current interrupt enable, visible on `cur_ie` the next cycle, unless a push or pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_bnd | input | 1 | Instruction boundary strobe |
| pc_in | input | 32 | PC of the instruction at the boundary |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Exception cause code |
| ret_req | input | 1 | Trap return request |
| ien_we | input | 1 | Write strobe for the current interrupt enable |
| ien_d | input | 1 | New current interrupt enable |
| tmr_en | input | 1 | Supervisor timer interrupt enable |
| m_sw_irq | input | 1 | Machine software interrupt pending |
| host_irq | input | 1 | Host message interrupt pending |
| s_sw_irq | input | 1 | Supervisor software interrupt pending |
| s_tmr_irq | input | 1 | Supervisor timer interrupt pending |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| cause | output | 32 | Trap cause register |
| epc | output | 32 | Saved exception PC |
| cur_priv | output | 2 | Current privilege level |
| cur_ie | output | 1 | Current interrupt enable |
| resv_kill | output | 1 | Load reservation cancel strobe |

## Verification
A corrupted stack slot stays hidden until enough returns bring it to the top. It then shows as a wrong `cur_priv` or `cur_ie`, or as a wrong vector and eligibility decision at the next trap. The bench therefore chains up to three returns after pushes, so every slot is driven out at the ports. A wrong cause, vector or EPC shows in the single redirect cycle one clock after the boundary. A stuck or doubled state shows as a missing or extra redirect, which the scoreboard reports as unexpected.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int IRQ_W = 2;
    localparam logic [IRQ_W-1:0] IRQ_SOFT  = 2'd0;
    localparam logic [IRQ_W-1:0] IRQ_TIMER = 2'd1;
    localparam logic [IRQ_W-1:0] IRQ_HOST  = 2'd2;

    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ENTER = 2'd2,
        ST_LEAVE = 2'd3
    } fsm_e;
endpackage

// File: rtl/trap_priv_stack.sv
module trap_priv_stack
    import trap_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  logic       ie_we,
    input  logic       ie_d,
    output logic [1:0] top_priv,
    output logic       top_ie
);
    localparam int STK_W = DEPTH * LVL_W;

    logic [STK_W-1:0] stk_q;
    logic [STK_W-1:0] stk_d;
    logic [STK_W-1:0] stk_rst;

    // slot 0 is the current level; higher slots are older levels
    for (genvar g = 0; g < DEPTH; g++) begin : g_rst
        if (g == 0) begin : g_top
            assign stk_rst[g*LVL_W +: LVL_W] = {PRIV_M, 1'b0};
        end else begin : g_low
            assign stk_rst[g*LVL_W +: LVL_W] = {PRIV_S, 1'b0};
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d = {stk_q[STK_W-LVL_W-1:0], PRIV_M, 1'b0};
        end else if (pop) begin
            stk_d = {PRIV_U, 1'b1, stk_q[STK_W-1:LVL_W]};
        end else if (ie_we) begin
            stk_d[0] = ie_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= stk_rst;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign top_priv = stk_q[2:1];
    assign top_ie   = stk_q[0];
endmodule

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
    import trap_pkg::*;
(
    input  logic [1:0]       priv,
    input  logic             ie,
    input  logic             tmr_en,
    input  logic             m_sw_irq,
    input  logic             host_irq,
    input  logic             s_sw_irq,
    input  logic             s_tmr_irq,
    output logic             take,
    output logic [IRQ_W-1:0] num
);
    logic m_ok;
    logic s_ok;

    always_comb begin
        m_ok = (priv != PRIV_M) || ie;
        s_ok = (priv == PRIV_U) || ((priv == PRIV_S) && ie);
        take = 1'b0;
        num  = IRQ_SOFT;
        if (m_ok && m_sw_irq) begin
            take = 1'b1;
            num  = IRQ_SOFT;
        end else if (m_ok && host_irq) begin
            take = 1'b1;
            num  = IRQ_HOST;
        end else if (s_ok && s_sw_irq) begin
            take = 1'b1;
            num  = IRQ_SOFT;
        end else if (s_ok && s_tmr_irq && tmr_en) begin
            take = 1'b1;
            num  = IRQ_TIMER;
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          CAUSE_W   = 4,
    parameter int          DEPTH     = 3,
    parameter int          VEC_SHIFT = 6,
    parameter logic [31:0] RESET_PC  = 32'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_bnd,
    input  logic [XLEN-1:0]    pc_in,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               ret_req,
    input  logic               ien_we,
    input  logic               ien_d,
    input  logic               tmr_en,
    input  logic               m_sw_irq,
    input  logic               host_irq,
    input  logic               s_sw_irq,
    input  logic               s_tmr_irq,
    output logic               redirect,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    cause,
    output logic [XLEN-1:0]    epc,
    output logic [1:0]         cur_priv,
    output logic               cur_ie,
    output logic               resv_kill
);
    localparam int PAD_W = XLEN - 1 - IRQ_W;

    fsm_e             state_q, state_d;
    logic             irq_take;
    logic [IRQ_W-1:0] irq_num;
    logic             do_push, do_pop;
    logic [XLEN-1:0]  pc_q, cause_q, epc_q;
    logic [XLEN-1:0]  vec;

    trap_priv_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .ie_we    (ien_we),
        .ie_d     (ien_d),
        .top_priv (cur_priv),
        .top_ie   (cur_ie)
    );

    trap_irq_pick u_pick (
        .priv      (cur_priv),
        .ie        (cur_ie),
        .tmr_en    (tmr_en),
        .m_sw_irq  (m_sw_irq),
        .host_irq  (host_irq),
        .s_sw_irq  (s_sw_irq),
        .s_tmr_irq (s_tmr_irq),
        .take      (irq_take),
        .num       (irq_num)
    );

    assign vec = XLEN'(cur_priv) << VEC_SHIFT;

    // next state and stack actions
    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN: begin
                if (insn_bnd && (irq_take || exc_req)) begin
                    do_push = 1'b1;
                    state_d = ST_ENTER;
                end else if (insn_bnd && ret_req) begin
                    do_pop  = 1'b1;
                    state_d = ST_LEAVE;
                end
            end
            ST_ENTER: state_d = ST_RUN;
            ST_LEAVE: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // trap registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= XLEN'(RESET_PC);
            cause_q <= '0;
            epc_q   <= '0;
        end else if (do_push) begin
            pc_q  <= vec;
            epc_q <= pc_in;
            if (irq_take) begin
                cause_q <= {1'b1, {PAD_W{1'b0}}, irq_num};
            end else begin
                cause_q <= XLEN'(exc_cause);
            end
        end else if (do_pop) begin
            pc_q <= epc_q;
        end
    end

    // outputs decoded from state
    always_comb begin
        redirect  = 1'b0;
        resv_kill = 1'b0;
        unique case (state_q)
            ST_BOOT:  redirect = 1'b1;
            ST_RUN:   redirect = 1'b0;
            ST_ENTER: begin
                redirect  = 1'b1;
                resv_kill = 1'b1;
            end
            ST_LEAVE: redirect = 1'b1;
            default:  redirect = 1'b0;
        endcase
    end

    assign redirect_pc = pc_q;
    assign cause       = cause_q;
    assign epc         = epc_q;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
    parameter int          XLEN      = 32,
    parameter int          VEC_SHIFT = 6,
    parameter logic [31:0] RESET_PC  = 32'h100
) (
    input logic            clk,
    input logic            rst_n,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] epc,
    input logic [1:0]      cur_priv,
    input logic            cur_ie,
    input logic            resv_kill
);
    // R1
    boot_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (redirect && redirect_pc == XLEN'(RESET_PC) && cur_priv == 2'd3));

    // R2
    entry_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_kill |-> (cur_priv == 2'd3 && !cur_ie));

    // R3
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !resv_kill && !$rose(rst_n)) |-> (redirect_pc == epc));

    // R4
    vector_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_kill |-> (redirect_pc[VEC_SHIFT-1:0] == '0 && redirect_pc[XLEN-1:VEC_SHIFT+2] == '0));

    // R8
    kill_with_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_kill |-> redirect);

    // R10
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);
endmodule

bind trap_ctrl trap_ctrl_chk #(
    .XLEN      (XLEN),
    .VEC_SHIFT (VEC_SHIFT),
    .RESET_PC  (RESET_PC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .epc         (epc),
    .cur_priv    (cur_priv),
    .cur_ie      (cur_ie),
    .resv_kill   (resv_kill)
);

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_bnd = 1'b0;
    logic [31:0] pc_in = '0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_cause = '0;
    logic        ret_req = 1'b0;
    logic        ien_we = 1'b0;
    logic        ien_d = 1'b0;
    logic        tmr_en = 1'b0;
    logic        m_sw_irq = 1'b0;
    logic        host_irq = 1'b0;
    logic        s_sw_irq = 1'b0;
    logic        s_tmr_irq = 1'b0;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic [31:0] cause;
    logic [31:0] epc;
    logic [1:0]  cur_priv;
    logic        cur_ie;
    logic        resv_kill;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] cause;
        logic [31:0] epc;
        logic [1:0]  priv;
        logic        ie;
        logic        kill;
        string       tag;
    } item_t;

    item_t exp_q[$];

    // reference model of the stack and trap registers
    logic [1:0]  m_p0 = 2'd3, m_p1 = 2'd1, m_p2 = 2'd1;
    logic        m_i0 = 1'b0, m_i1 = 1'b0, m_i2 = 1'b0;
    logic [31:0] m_epc = '0, m_cause = '0;

    trap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .pc_in(pc_in),
        .exc_req(exc_req), .exc_cause(exc_cause), .ret_req(ret_req),
        .ien_we(ien_we), .ien_d(ien_d), .tmr_en(tmr_en),
        .m_sw_irq(m_sw_irq), .host_irq(host_irq), .s_sw_irq(s_sw_irq),
        .s_tmr_irq(s_tmr_irq), .redirect(redirect), .redirect_pc(redirect_pc),
        .cause(cause), .epc(epc), .cur_priv(cur_priv), .cur_ie(cur_ie),
        .resv_kill(resv_kill)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string act, input string expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %s expected %s", tag, act, expv);
        end
    endtask

    // monitor: pops one expected item per redirect
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && redirect) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected redirect", $sformatf("pc=%h", redirect_pc), "none");
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(redirect_pc == e.pc && cause == e.cause && epc == e.epc &&
                          cur_priv == e.priv && cur_ie == e.ie && resv_kill == e.kill, e.tag,
                          $sformatf("pc=%h cause=%h epc=%h priv=%0d ie=%0d kill=%0d",
                                    redirect_pc, cause, epc, cur_priv, cur_ie, resv_kill),
                          $sformatf("pc=%h cause=%h epc=%h priv=%0d ie=%0d kill=%0d",
                                    e.pc, e.cause, e.epc, e.priv, e.ie, e.kill));
                end
            end
        end
    end

    // driver: one boundary with the given requests, expectation from the model
    task automatic step(input logic exc, input logic [3:0] ec, input logic ret,
                        input logic msw, input logic hst, input logic ssw, input logic stm,
                        input logic [31:0] pc, input string tag);
        bit m_ok, s_ok, irq, any;
        logic [1:0] num;
        item_t e;
        @(negedge clk);
        exc_req = exc; exc_cause = ec; ret_req = ret;
        m_sw_irq = msw; host_irq = hst; s_sw_irq = ssw; s_tmr_irq = stm;
        pc_in = pc; insn_bnd = 1'b1;
        m_ok = (m_p0 != 2'd3) || m_i0;
        s_ok = (m_p0 == 2'd0) || (m_p0 == 2'd1 && m_i0);
        irq = 1'b1; num = 2'd0;
        if (m_ok && msw) num = 2'd0;
        else if (m_ok && hst) num = 2'd2;
        else if (s_ok && ssw) num = 2'd0;
        else if (s_ok && stm && tmr_en) num = 2'd1;
        else irq = 1'b0;
        any = 1'b1;
        e.tag = tag;
        if (irq || exc) begin
            e.pc = 32'(m_p0) * 32'h40;
            m_cause = irq ? {1'b1, 29'd0, num} : {28'd0, ec};
            m_epc = pc;
            m_p2 = m_p1; m_i2 = m_i1; m_p1 = m_p0; m_i1 = m_i0; m_p0 = 2'd3; m_i0 = 1'b0;
            e.kill = 1'b1;
        end else if (ret) begin
            e.pc = m_epc;
            m_p0 = m_p1; m_i0 = m_i1; m_p1 = m_p2; m_i1 = m_i2; m_p2 = 2'd0; m_i2 = 1'b1;
            e.kill = 1'b0;
        end else begin
            any = 1'b0;
        end
        e.cause = m_cause; e.epc = m_epc; e.priv = m_p0; e.ie = m_i0;
        if (any) exp_q.push_back(e);
        @(negedge clk);
        insn_bnd = 1'b0; exc_req = 1'b0; ret_req = 1'b0;
        m_sw_irq = 1'b0; host_irq = 1'b0; s_sw_irq = 1'b0; s_tmr_irq = 1'b0;
        if (!any) check(redirect == 1'b0, {tag, " no trap"}, $sformatf("%0d", redirect), "0");
    endtask

    task automatic set_ie(input logic v);
        @(negedge clk);
        ien_we = 1'b1; ien_d = v;
        @(negedge clk);
        ien_we = 1'b0;
        m_i0 = v;
        check(cur_ie == v, "R11 enable write", $sformatf("%0d", cur_ie), $sformatf("%0d", v));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(redirect == 1'b1 && redirect_pc == 32'h100, "R1 reset redirect",
              $sformatf("%0d %h", redirect, redirect_pc), "1 00000100");
        check(cur_priv == 2'd3 && cur_ie == 1'b0 && cause == 0 && epc == 0, "R1 reset state",
              $sformatf("%0d %0d %h %h", cur_priv, cur_ie, cause, epc), "3 0 0 0");
        rst_n = 1'b1;
        @(negedge clk);
        check(redirect == 1'b0, "R1 boot redirect one cycle", $sformatf("%0d", redirect), "0");
        mon_en = 1'b1;

        step(1, 4'd5, 0, 0, 0, 0, 0, 32'h1000, "R2 R4 R7 R8 exception at machine");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h1004, "R3 return to saved machine");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h1008, "R3 return to supervisor");
        step(0, 4'd0, 0, 1, 1, 0, 0, 32'h2000, "R5 machine soft over host below machine");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h2004, "R3 return after interrupt");
        tmr_en = 1'b1;
        step(0, 4'd0, 0, 0, 0, 0, 1, 32'h2008, "R6 supervisor disabled");
        set_ie(1'b1);
        step(0, 4'd0, 0, 0, 0, 1, 1, 32'h2100, "R6 R7 supervisor soft over timer");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h2104, "R3 return restores enable");
        tmr_en = 1'b0;
        step(0, 4'd0, 0, 0, 0, 0, 1, 32'h2108, "R6 timer gated by tmr_en");
        tmr_en = 1'b1;
        step(1, 4'd3, 0, 0, 0, 0, 1, 32'h210c, "R9 R6 timer wins over exception");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h2110, "R3 return to supervisor again");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h2114, "R3 return to user refill");
        step(0, 4'd0, 0, 0, 1, 0, 0, 32'h3000, "R5 R4 host from user vector zero");
        step(1, 4'd2, 1, 1, 1, 0, 0, 32'h4000, "R9 R5 trap over return machine disabled");
        set_ie(1'b1);
        step(0, 4'd0, 0, 0, 1, 0, 0, 32'h4100, "R5 host at machine enabled");
        step(0, 4'd0, 1, 0, 0, 0, 0, 32'h4104, "R3 return pops machine enable");

        // R10 requests without a boundary are ignored
        @(negedge clk);
        exc_req = 1'b1; exc_cause = 4'd7; ret_req = 1'b1; m_sw_irq = 1'b1;
        @(negedge clk);
        check(redirect == 1'b0, "R10 no boundary ignored", $sformatf("%0d", redirect), "0");
        exc_req = 1'b0; ret_req = 1'b0; m_sw_irq = 1'b0;
        @(negedge clk);
        check(cur_priv == m_p0 && cur_ie == m_i0, "R10 level unchanged",
              $sformatf("%0d %0d", cur_priv, cur_ie), $sformatf("%0d %0d", m_p0, m_i0));

        // R10 boundary held during the redirect cycle gives one trap only
        step(1, 4'd9, 0, 0, 0, 0, 0, 32'h5000, "R10 single trap");
        @(negedge clk);
        exc_req = 1'b1; exc_cause = 4'd9; insn_bnd = 1'b1;
        begin
            item_t e;
            e.pc = 32'(m_p0) * 32'h40; e.cause = 32'd9; e.epc = 32'h5000;
            m_p2 = m_p1; m_i2 = m_i1; m_p1 = m_p0; m_i1 = m_i0; m_p0 = 2'd3; m_i0 = 1'b0;
            e.priv = 2'd3; e.ie = 1'b0; e.kill = 1'b1; e.tag = "R10 held boundary entry";
            m_epc = 32'h5000; m_cause = 32'd9;
            exp_q.push_back(e);
        end
        pc_in = 32'h5000;
        @(negedge clk);
        pc_in = 32'h6000;
        @(negedge clk);
        insn_bnd = 1'b0; exc_req = 1'b0;
        check(redirect == 1'b0, "R10 boundary in redirect ignored", $sformatf("%0d", redirect), "0");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all redirects seen", $sformatf("%0d", exp_q.size()), "0");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule